// File: doc/BRIEF.md
# I2C Slave Responder with General Call

This block is the target side of an I2C bus. It watches open-drain SCL and SDA and finds START and STOP conditions. It compares each address byte with a programmed 7-bit own address, or with the general-call address if that is enabled. It then receives or sends data bytes. Each event on the bus is reported to a host as an 8-bit status code, together with an interrupt flag.

While a byte event is pending, the responder holds SCL low. The host therefore has as long as it needs to read the received byte, supply the next byte to send, or decide whether the next byte gets an ACK. The host gives that decision through an assert-acknowledge input, one byte at a time. It ends the hold by pulsing a clear input.

The host-side registers are modelled as plain level inputs: the address configuration, the assert-acknowledge bit and the byte to send. The received byte, the status code and the flag come out on ports. The pins are modelled as an input plus an active-high "pull low" enable for each line.

Top module: `i2cs_responder`

## Requirements
- R1: `ownCfg[7:1]` holds the own 7-bit address. An address byte equal to `{ownCfg[7:1],0}` is acknowledged when `ackEn`=1. It then raises `irq` with status 0x60.
- R2: The general-call address byte is 0x00. It is acknowledged, with status 0x70, only when `ownCfg[0]`=1 and `ackEn`=1. With `ownCfg[0]`=0 it gets no ACK and no `irq`.
- R3: The address byte 0x01 (general call with the read bit) is never acknowledged and raises no `irq`.
- R4: A data byte received after an own write address appears on `rxByte`. It reports 0x80 if `ackEn`=1 caused an ACK and 0x88 if it got a NACK. After 0x88 the responder ignores the bus until the next START.
- R5: A data byte received after a general call reports 0x90 on ACK and 0x98 on NACK.
- R6: A STOP, or a repeated START, seen while addressed reports 0xA0 and does not hold SCL. After a repeated START the next address byte is handled as usual.
- R7: The address byte `{ownCfg[7:1],1}` with `ackEn`=1 reports 0xA8. When the host clears the flag, `txByte` is loaded and sent MSB first. SDA is changed only while SCL is low.
- R8: After each sent byte the status is 0xB8 if the master ACKed and 0xC0 if it NACKed. If `ackEn` was 0 when the byte was loaded and the master ACKs, the status is 0xC8. After 0xC0 or 0xC8, SDA stays released until the next START.
- R9: With `ackEn`=0, the own address gets no ACK and no `irq`, and the rest of that transfer is ignored.
- R10: After every byte event `sclOe` holds SCL low while `irq` is set. It is released in the cycle after an `irqClear` pulse.
- R11: `status` reads 0xF8 whenever `irq` is 0. After reset, `irq`=0 and both pins are released. `irq` stays set until it is cleared.
- R12: An address byte that matches neither the own address nor an enabled general call gets no ACK and no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| ownCfg | input | 8 | Own address in [7:1], general-call enable in [0] |
| ackEn | input | 1 | Acknowledge the next address or data byte |
| txByte | input | 8 | Byte sent on the next read slot |
| irqClear | input | 1 | One-cycle pulse that clears the event flag |
| rxByte | output | 8 | Last received data byte |
| status | output | 8 | Event code, 0xF8 when idle |
| irq | output | 1 | Event pending flag |

## Verification
The bench builds the responder with `SYNC_STAGES`=3, one stage more than the default. It drives the bus with a 16-cycle half bit period. The deeper synchronizer pushes ACK drive, SDA release and the start of the SCL hold later into the low phase, so the bench shows that each still lands before the master's next rising edge. With a master that waits on the wired SCL level, this setting also exposes any event that would be decided on a stale line sample.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_BITS = 8;

  localparam logic [BYTE_BITS-1:0] ST_OWN_WR    = 8'h60;
  localparam logic [BYTE_BITS-1:0] ST_GC_WR     = 8'h70;
  localparam logic [BYTE_BITS-1:0] ST_OWN_DACK  = 8'h80;
  localparam logic [BYTE_BITS-1:0] ST_OWN_DNACK = 8'h88;
  localparam logic [BYTE_BITS-1:0] ST_GC_DACK   = 8'h90;
  localparam logic [BYTE_BITS-1:0] ST_GC_DNACK  = 8'h98;
  localparam logic [BYTE_BITS-1:0] ST_STOPPED   = 8'hA0;
  localparam logic [BYTE_BITS-1:0] ST_OWN_RD    = 8'hA8;
  localparam logic [BYTE_BITS-1:0] ST_TX_ACKED  = 8'hB8;
  localparam logic [BYTE_BITS-1:0] ST_TX_NACKED = 8'hC0;
  localparam logic [BYTE_BITS-1:0] ST_TX_LAST   = 8'hC8;
  localparam logic [BYTE_BITS-1:0] ST_NONE      = 8'hF8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT
  } respState_t;

  typedef struct packed {
    logic clrCnt;
    logic sampleBit;
    logic loadTx;
    logic shiftTx;
    logic captureRx;
  } dpStrobe_t;

  typedef struct packed {
    logic startC;
    logic stopC;
    logic sclRise;
    logic sclFall;
    logic sclHigh;
    logic byteDone;
  } busEv_t;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [BYTE_BITS-1:0] txByte,
  input  dpStrobe_t            stb,
  output busEv_t               ev,
  output logic                 sdaNow,
  output logic                 txBit,
  output logic [BYTE_BITS-1:0] shByte,
  output logic [BYTE_BITS-1:0] rxByte
);
  localparam int CNT_W = $clog2(BYTE_BITS + 2);

  logic sclS, sdaS, sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_BITS-1:0] shReg;

  // Input synchronizers: the depth is picked by parameter
  if (SYNC_STAGES > 1) begin : gSyncChain
    logic [SYNC_STAGES-1:0] sclSync, sdaSync;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclSync <= '1;
        sdaSync <= '1;
      end else begin
        sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
        sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      end
    end
    assign sclS = sclSync[SYNC_STAGES-1];
    assign sdaS = sdaSync[SYNC_STAGES-1];
  end else begin : gSyncSingle
    logic sclR, sdaR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclR <= 1'b1;
        sdaR <= 1'b1;
      end else begin
        sclR <= sclIn;
        sdaR <= sdaIn;
      end
    end
    assign sclS = sclR;
    assign sdaS = sdaR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign ev.startC   = sclS & sclQ & sdaQ & ~sdaS;
  assign ev.stopC    = sclS & sclQ & ~sdaQ & sdaS;
  assign ev.sclRise  = sclS & ~sclQ;
  assign ev.sclFall  = ~sclS & sclQ;
  assign ev.sclHigh  = sclS;
  assign ev.byteDone = (bitCnt == CNT_W'(BYTE_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (stb.clrCnt) bitCnt <= '0;
    else if (ev.sclRise) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (stb.loadTx) shReg <= txByte;
    else if (stb.sampleBit) shReg <= {shReg[BYTE_BITS-2:0], sdaS};
    else if (stb.shiftTx) shReg <= {shReg[BYTE_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (stb.captureRx) rxByte <= shReg;
  end

  assign sdaNow = sdaS;
  assign txBit  = shReg[BYTE_BITS-1];
  assign shByte = shReg;

  // R7: the byte to send is taken from txByte on a load strobe
  assert_tx_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> shByte == $past(txByte));
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  busEv_t               ev,
  input  logic                 sdaNow,
  input  logic                 txBit,
  input  logic [BYTE_BITS-1:0] shByte,
  input  logic [BYTE_BITS-1:0] ownCfg,
  input  logic                 ackEn,
  input  logic                 irqClear,
  output dpStrobe_t            stb,
  output logic                 sclOe,
  output logic                 sdaOe,
  output logic [BYTE_BITS-1:0] status,
  output logic                 irq
);
  respState_t state, retState;
  logic isGc, isRead, lastByte, ackOut, mAck, hold;
  logic [BYTE_BITS-1:0] code;
  logic ownHit, gcHit, addressed;

  assign ownHit = (shByte[BYTE_BITS-1:1] == ownCfg[BYTE_BITS-1:1]) && ackEn;
  assign gcHit  = (shByte == '0) && ownCfg[0] && ackEn;
  assign addressed = (state inside {S_RX, S_RX_ACK, S_TX, S_TX_ACK}) ||
                     (state == S_WAIT && retState != S_IDLE);

  always_comb begin
    stb = '0;
    if (ev.startC) stb.clrCnt = 1'b1;
    else if (!ev.stopC) begin
      case (state)
        S_ADDR: stb.sampleBit = ev.sclRise;
        S_RX: begin
          stb.sampleBit = ev.sclRise;
          stb.captureRx = ev.sclFall && ev.byteDone;
        end
        S_TX:   stb.shiftTx = ev.sclFall && !ev.byteDone;
        S_WAIT: begin
          stb.clrCnt = irqClear;
          stb.loadTx = irqClear && (retState == S_TX);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
      isGc     <= 1'b0;
      isRead   <= 1'b0;
      lastByte <= 1'b0;
      ackOut   <= 1'b0;
      mAck     <= 1'b0;
      hold     <= 1'b0;
      irq      <= 1'b0;
      code     <= ST_NONE;
    end else begin
      if (irqClear) irq <= 1'b0;
      if (ev.stopC || ev.startC) begin
        if (addressed) begin
          irq  <= 1'b1;
          code <= ST_STOPPED;
          hold <= 1'b0;
        end
        ackOut <= 1'b0;
        state  <= ev.startC ? S_ADDR : S_IDLE;
      end else begin
        case (state)
          S_ADDR: if (ev.sclFall && ev.byteDone) begin
            if (ownHit || gcHit) begin
              ackOut <= 1'b1;
              isGc   <= gcHit;
              isRead <= shByte[0];
              state  <= S_ADDR_ACK;
            end else state <= S_IDLE;
          end
          S_ADDR_ACK: if (ev.sclFall) begin
            ackOut   <= 1'b0;
            irq      <= 1'b1;
            hold     <= 1'b1;
            code     <= isGc ? ST_GC_WR : (isRead ? ST_OWN_RD : ST_OWN_WR);
            retState <= isRead ? S_TX : S_RX;
            state    <= S_WAIT;
          end
          S_RX: if (ev.sclFall && ev.byteDone) begin
            ackOut <= ackEn;
            state  <= S_RX_ACK;
          end
          S_RX_ACK: if (ev.sclFall) begin
            ackOut   <= 1'b0;
            irq      <= 1'b1;
            hold     <= 1'b1;
            code     <= isGc ? (ackOut ? ST_GC_DACK : ST_GC_DNACK)
                             : (ackOut ? ST_OWN_DACK : ST_OWN_DNACK);
            retState <= ackOut ? S_RX : S_IDLE;
            state    <= S_WAIT;
          end
          S_TX: if (ev.sclFall && ev.byteDone) state <= S_TX_ACK;
          S_TX_ACK: begin
            if (ev.sclRise) mAck <= ~sdaNow;
            if (ev.sclFall) begin
              irq      <= 1'b1;
              hold     <= 1'b1;
              code     <= mAck ? (lastByte ? ST_TX_LAST : ST_TX_ACKED) : ST_TX_NACKED;
              retState <= (mAck && !lastByte) ? S_TX : S_IDLE;
              state    <= S_WAIT;
            end
          end
          S_WAIT: if (irqClear) begin
            state <= retState;
            if (retState == S_TX) lastByte <= ~ackEn;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign sclOe  = irq && hold;
  assign sdaOe  = ackOut || (state == S_TX && !txBit);
  assign status = irq ? code : ST_NONE;

  // R7: SDA drive never changes while SCL is seen high
  assert_sda_quiet_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ev.sclHigh && $past(ev.sclHigh)) |-> $stable(sdaOe));
  // R9: with acknowledge disabled an address byte leaves SDA released
  assert_no_ack_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && ev.sclFall && ev.byteDone && !ackEn && !ev.startC && !ev.stopC)
      |=> (state == S_IDLE && !sdaOe));
  // R3: general call with read bit is not acknowledged
  assert_gc_read_nack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && ev.sclFall && ev.byteDone && shByte == 8'h01 &&
     ownCfg[BYTE_BITS-1:1] != '0 && !ev.startC && !ev.stopC) |=> !sdaOe);
  // R2: a general-call event needs the enable bit
  assert_gc_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irq) && code == ST_GC_WR) |-> $past(ownCfg[0]));
  // R10: a byte event holds SCL low as the flag rises
  assert_stretch_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irq) && code != ST_STOPPED) |-> sclOe);
  // R11: the flag stays set until cleared
  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClear) |=> irq);
endmodule

// File: rtl/i2cs_responder.sv
module i2cs_responder
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclOe,
  output logic                 sdaOe,
  input  logic [BYTE_BITS-1:0] ownCfg,
  input  logic                 ackEn,
  input  logic [BYTE_BITS-1:0] txByte,
  input  logic                 irqClear,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic [BYTE_BITS-1:0] status,
  output logic                 irq
);
  dpStrobe_t stb;
  busEv_t ev;
  logic sdaNow, txBit;
  logic [BYTE_BITS-1:0] shByte;

  i2cs_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .txByte(txByte),
    .stb(stb), .ev(ev), .sdaNow(sdaNow), .txBit(txBit), .shByte(shByte),
    .rxByte(rxByte)
  );

  i2cs_control ctl_i (
    .clk(clk), .rstN(rstN), .ev(ev), .sdaNow(sdaNow), .txBit(txBit),
    .shByte(shByte), .ownCfg(ownCfg), .ackEn(ackEn), .irqClear(irqClear),
    .stb(stb), .sclOe(sclOe), .sdaOe(sdaOe), .status(status), .irq(irq)
  );
endmodule

// File: tb/i2cs_responder_tb_top.sv
`timescale 1ns/1ps
module i2cs_responder_tb_top;
  localparam int H = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclOe, sdaOe, ackEn, irqClear, irq;
  logic [7:0] ownCfg, txByte, rxByte, status;
  logic sclLine, sdaLine;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sclLine = sclM & ~sclOe;
  assign sdaLine = sdaM & ~sdaOe;

  i2cs_responder #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe),
    .sdaOe(sdaOe), .ownCfg(ownCfg), .ackEn(ackEn), .txByte(txByte),
    .irqClear(irqClear), .rxByte(rxByte), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic r);
    sdaM = b; waitClk(H);
    sclM = 1'b1; wait (sclLine === 1'b1); waitClk(H);
    r = sdaLine; sclM = 1'b0; waitClk(H);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; wait (sclLine === 1'b1); waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(H);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; wait (sclLine === 1'b1); waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clockBit(v[i], r);
    clockBit(1'b1, r);
    acked = !r;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, r);
      v[i] = r;
    end
    clockBit(!giveAck, r);
  endtask

  task automatic clearIrq();
    @(negedge clk) irqClear = 1'b1;
    @(negedge clk) irqClear = 1'b0;
    waitClk(2);
  endtask

  // Expect a byte event: flag, code and SCL hold
  task automatic expectEvent(input string tag, input logic [7:0] code);
    chk({tag, " irq"}, irq, 1'b1);
    chk({tag, " status"}, status, code);
    chk({tag, " R10 hold"}, sclOe, 1'b1);
  endtask

  // Every clock: idle status must read 0xF8 (R11)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (!irq && status !== 8'hF8) begin
        fails++;
        $display("FAIL R11 idle status got %0h expected f8", status);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    ownCfg = {7'h5A, 1'b1}; ackEn = 1'b1; txByte = 8'h00; irqClear = 1'b0;
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R11 reset state
    chk("R11 reset irq", irq, 1'b0);
    chk("R11 reset status", status, 8'hF8);
    chk("R11 reset pins", {sclOe, sdaOe}, 2'b00);

    // R1 own write, R4 data ACK/NACK, then ignore
    busStart(); sendByte(8'hB4, a);
    chk("R1 addr ack", a, 1'b1); expectEvent("R1", 8'h60);
    clearIrq(); chk("R10 released", sclOe, 1'b0);
    sendByte(8'h3C, a); chk("R4 data ack", a, 1'b1);
    expectEvent("R4", 8'h80); chk("R4 rxByte", rxByte, 8'h3C);
    clearIrq(); ackEn = 1'b0;
    sendByte(8'hC3, a); chk("R4 data nack", a, 1'b0);
    expectEvent("R4", 8'h88); chk("R4 rxByte2", rxByte, 8'hC3);
    clearIrq(); ackEn = 1'b1;
    sendByte(8'h11, a); chk("R4 ignored ack", a, 1'b0);
    chk("R4 ignored irq", irq, 1'b0);
    busStop(); chk("R4 no stop event", irq, 1'b0);

    // R2 / R5 general call
    busStart(); sendByte(8'h00, a);
    chk("R2 gc ack", a, 1'b1); expectEvent("R2", 8'h70);
    clearIrq(); sendByte(8'hA5, a); chk("R5 ack", a, 1'b1);
    expectEvent("R5", 8'h90); chk("R5 rxByte", rxByte, 8'hA5);
    clearIrq(); ackEn = 1'b0;
    sendByte(8'h5B, a); chk("R5 nack", a, 1'b0); expectEvent("R5", 8'h98);
    clearIrq(); ackEn = 1'b1; busStop();

    // R2 general call disabled
    ownCfg = {7'h5A, 1'b0};
    busStart(); sendByte(8'h00, a);
    chk("R2 gc disabled ack", a, 1'b0); chk("R2 gc disabled irq", irq, 1'b0);
    busStop(); ownCfg = {7'h5A, 1'b1};

    // R3 general call with read bit
    busStart(); sendByte(8'h01, a);
    chk("R3 gc read ack", a, 1'b0); chk("R3 gc read irq", irq, 1'b0); busStop();

    // R9 acknowledge disabled on own address
    ackEn = 1'b0;
    busStart(); sendByte(8'hB4, a);
    chk("R9 addr ack", a, 1'b0); chk("R9 irq", irq, 1'b0);
    sendByte(8'h77, a); chk("R9 data ignored", a, 1'b0);
    busStop(); chk("R9 no stop event", irq, 1'b0); ackEn = 1'b1;

    // R12 foreign address
    busStart(); sendByte(8'h44, a);
    chk("R12 ack", a, 1'b0); chk("R12 irq", irq, 1'b0); busStop();

    // R6 STOP while addressed
    busStart(); sendByte(8'hB4, a); expectEvent("R6 addr", 8'h60); clearIrq();
    sendByte(8'h69, a); expectEvent("R6 data", 8'h80); clearIrq();
    busStop();
    chk("R6 stop irq", irq, 1'b1); chk("R6 stop status", status, 8'hA0);
    chk("R10 no hold on stop", sclOe, 1'b0); clearIrq();

    // R6 repeated START, R7 read, R8 B8/C0
    busStart(); sendByte(8'hB4, a); expectEvent("R6 addr2", 8'h60); clearIrq();
    busStart();
    chk("R6 restart irq", irq, 1'b1); chk("R6 restart status", status, 8'hA0);
    clearIrq();
    sendByte(8'hB5, a); chk("R7 read addr ack", a, 1'b1);
    expectEvent("R7", 8'hA8);
    txByte = 8'h96; clearIrq();
    readByte(1'b1, v); chk("R7 tx byte", v, 8'h96); expectEvent("R8 acked", 8'hB8);
    txByte = 8'h5C; clearIrq();
    readByte(1'b0, v); chk("R7 tx byte2", v, 8'h5C); expectEvent("R8 nacked", 8'hC0);
    clearIrq(); chk("R8 sda released", sdaOe, 1'b0);
    busStop(); chk("R8 no stop event", irq, 1'b0);

    // R8 last byte with master ACK
    busStart(); sendByte(8'hB5, a); expectEvent("R7 addr2", 8'hA8);
    ackEn = 1'b0; txByte = 8'hE1; clearIrq();
    readByte(1'b1, v); chk("R7 tx byte3", v, 8'hE1); expectEvent("R8 last", 8'hC8);
    clearIrq(); ackEn = 1'b1;
    chk("R8 released after last", sdaOe, 1'b0);
    busStop(); chk("R8 no stop after last", irq, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule